// File: doc/BRIEF.md
# Masked source/target ID match counter

This block counts one kind of event on a coherence agent or ring interface, and it counts it only for the traffic that software wants to see. Every event arrives with an event code, an 11-bit source cluster ID, an 11-bit target cluster ID and a 2-bit channel tag. Software picks the event code to count. It can narrow the count to particular sources and targets with a compare value and a per-bit don't-care mask for each ID. For a fixed window of event codes it can also narrow the count to one transmit ring channel.

A cluster ID holds a 6-bit die ID in bits [10:5] and a 5-bit cluster code in bits [4:0]. Masking bits [4:0] selects a whole die, and masking bits [10:5] selects one cluster position on every die. On I/O dies the cluster codes are 5'b00000 for management, 5'b00001 for network, 5'b00011 for accelerator and 5'b10000 for PCIe. The count is 48 bits wide and wraps. It has a sticky overflow flag, and software can clear it or preset it through the register port.

Top module: `idm_event_counter`

## Requirements
- R1: After reset the counter and overflow flag are zero, both ID compare values are zero, both ID masks are all ones, and the control register (event select in bits [7:0], channel selector in bits [9:8]) is zero.
- R2: On a clock edge where `ev_valid_i` is high, `ev_code_i` equals the selected code and every filter passes, the counter grows by exactly one. The new value can be read in the following cycle. In any other cycle with no register write to the counter, the counter holds its value.
- R3: Source filter: the event passes when every source ID bit whose mask bit (address 1) is 0 equals the same bit of the source compare value (address 0). Source ID bits whose mask bit is 1 are ignored.
- R4: Target filter: the same rule applies with its own target compare value (address 2) and target mask (address 3), independent of the source filter.
- R5: Channel filter, for selected codes 0x47 to 0x59 inclusive. Tag bit 0 marks the extended ring channel and tag bit 1 marks the normal ring channel. Selector 2'b01 and 2'b11 pass only events with tag bit 0 set. Selector 2'b10 passes only events with tag bit 1 set. Selector 2'b00 passes all events.
- R6: For a selected code outside 0x47 to 0x59, the channel selector has no effect on counting.
- R7: With the reset configuration (all filters open), every valid event whose code equals the selected code is counted, whatever its IDs and tag.
- R8: The counter is 48 bits and wraps from all ones to zero. The wrap sets an overflow flag, read as bit 31 of address 6. The flag stays set until a clear.
- R9: Writing 1 in bit 0 to address 7 zeroes the counter and the overflow flag. This clear takes priority over a preset and over an event in the same cycle.
- R10: Writing address 5 presets counter bits [31:0], and writing address 6 presets bits [47:32] from write-data bits [15:0]. A preset takes priority over an event in the same cycle. Address 5 reads counter bits [31:0], and address 6 reads bits [47:32] in [15:0].
- R11: A register write changes the filter configuration from the next cycle on. An event in the same cycle as the write is judged by the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register write address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_raddr_i | input | 3 | Register read address |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| ev_valid_i | input | 1 | Event occurrence this cycle |
| ev_code_i | input | 8 | Event code |
| ev_src_i | input | 11 | Source cluster ID |
| ev_tgt_i | input | 11 | Target cluster ID |
| ev_chan_i | input | 2 | Channel tag: bit 0 extended ring, bit 1 normal ring |

## Verification
The bench goes after both edges of the channel window, 0x47 and 0x59, and after the codes just outside them. A design with an off-by-one window would filter 0x46 or 0x5A, or would let 0x59 through unfiltered. It drives selector 2'b01 against 2'b11 and checks that they behave the same; a design that decoded only one of them would count the wrong channel. Masks that cover only the die bits or only the cluster bits catch a swapped or inverted mask sense. A preset to just below all ones, followed by events, exposes a counter that saturates or that loses the sticky overflow flag. A clear issued in the same cycle as an event catches wrong priority, because the count would read 1 instead of 0.

// File: rtl/idm_pkg.sv
package idm_pkg;

   // Register addresses of the configuration port
   typedef enum logic [2:0] {
      RA_SRC_CMP = 3'd0,
      RA_SRC_MSK = 3'd1,
      RA_TGT_CMP = 3'd2,
      RA_TGT_MSK = 3'd3,
      RA_CTRL    = 3'd4,
      RA_CNT_LO  = 3'd5,
      RA_CNT_HI  = 3'd6,
      RA_CLEAR   = 3'd7
   } idm_reg_e;

   // Channel selector codes
   localparam logic [1:0] CHS_ALL  = 2'b00;
   localparam logic [1:0] CHS_EXT  = 2'b01;
   localparam logic [1:0] CHS_NORM = 2'b10;
   localparam logic [1:0] CHS_EXT2 = 2'b11;

   // Channel tag bit positions
   localparam int TAG_EXT_BIT  = 0;
   localparam int TAG_NORM_BIT = 1;

endpackage

// File: rtl/idm_id_match.sv
module idm_id_match #(
   parameter int ID_W = 11
) (
   input  logic [ID_W-1:0] id_i,
   input  logic [ID_W-1:0] cmp_i,
   input  logic [ID_W-1:0] msk_i,
   output logic            hit_o
);

   logic [ID_W-1:0] bit_ok;

   // one comparator cell per ID bit, bypassed when masked
   for (genvar b = 0; b < ID_W; b++) begin : g_bit
      assign bit_ok[b] = msk_i[b] | ~(id_i[b] ^ cmp_i[b]);
   end

   assign hit_o = &bit_ok;

   // R3 / R4: a fully masked ID always matches, an exact ID always matches
   always_comb begin
      p_full_mask_hit_r3 : assert (!(&msk_i) || hit_o);
      p_exact_id_hit_r4  : assert ((id_i != cmp_i) || hit_o);
   end

endmodule

// File: rtl/idm_chan_filter.sv
module idm_chan_filter
   import idm_pkg::*;
#(
   parameter int              CODE_W  = 8,
   parameter logic [CODE_W-1:0] WIN_LO = 8'h47,
   parameter logic [CODE_W-1:0] WIN_HI = 8'h59
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [1:0]        sel_i,
   input  logic [1:0]        tag_i,
   output logic              pass_o
);

   if (WIN_LO > WIN_HI) begin : g_bad_win
      $error("idm_chan_filter: WIN_LO above WIN_HI");
   end

   logic in_win;
   logic chan_ok;

   assign in_win = (code_i >= WIN_LO) && (code_i <= WIN_HI);

   always_comb begin
      unique case (sel_i)
         CHS_ALL:            chan_ok = 1'b1;
         CHS_NORM:           chan_ok = tag_i[TAG_NORM_BIT];
         CHS_EXT, CHS_EXT2:  chan_ok = tag_i[TAG_EXT_BIT];
         default:            chan_ok = 1'b1;
      endcase
   end

   assign pass_o = !in_win || chan_ok;

   // R6: outside the window the selector never blocks; R5: 2'b00 never blocks
   always_comb begin
      p_outside_window_pass_r6 : assert (in_win || pass_o);
      p_sel_all_pass_r5        : assert ((sel_i != CHS_ALL) || pass_o);
   end

endmodule

// File: rtl/idm_counter.sv
module idm_counter #(
   parameter int CNT_W  = 48,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ld_lo_i,
   input  logic              ld_hi_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic              inc_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o
);

   localparam int HI_W = CNT_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_width
      $error("idm_counter: CNT_W must exceed DATA_W by 1..DATA_W-1 bits");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (ld_lo_i || ld_hi_i) begin
         if (ld_lo_i) cnt_q[DATA_W-1:0]     <= ld_data_i;
         if (ld_hi_i) cnt_q[CNT_W-1:DATA_W] <= ld_data_i[HI_W-1:0];
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
         if (&cnt_q) ovf_q <= 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   p_clear_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0) && !ovf_q);
   p_step_one_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && !ld_lo_i && !ld_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_hold_idle_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q));
   p_sticky_ovf_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_i) |=> ovf_q);
   p_wrap_sets_ovf_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && (&cnt_q) && !clr_i && !ld_lo_i && !ld_hi_i) |=> (ovf_q && cnt_q == '0));

endmodule

// File: rtl/idm_event_counter.sv
module idm_event_counter
   import idm_pkg::*;
#(
   parameter int                ID_W   = 11,
   parameter int                CODE_W = 8,
   parameter int                CNT_W  = 48,
   parameter int                DATA_W = 32,
   parameter logic [CODE_W-1:0] WIN_LO = 8'h47,
   parameter logic [CODE_W-1:0] WIN_HI = 8'h59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_i,
   input  logic [2:0]        cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic [2:0]        cfg_raddr_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   input  logic              ev_valid_i,
   input  logic [CODE_W-1:0] ev_code_i,
   input  logic [ID_W-1:0]   ev_src_i,
   input  logic [ID_W-1:0]   ev_tgt_i,
   input  logic [1:0]        ev_chan_i
);

   localparam int HI_W    = CNT_W - DATA_W;
   localparam int CHS_LSB = CODE_W;

   if (ID_W > DATA_W) begin : g_bad_id
      $error("idm_event_counter: ID_W exceeds DATA_W");
   end
   if (CODE_W + 2 > DATA_W) begin : g_bad_code
      $error("idm_event_counter: control field does not fit");
   end

   // ---------------- configuration registers ----------------
   logic [ID_W-1:0]   src_cmp_q, src_msk_q, tgt_cmp_q, tgt_msk_q;
   logic [CODE_W-1:0] sel_code_q;
   logic [1:0]        chan_sel_q;

   logic wr_clr, wr_lo, wr_hi;

   assign wr_clr = cfg_wr_i && (cfg_addr_i == RA_CLEAR) && cfg_wdata_i[0];
   assign wr_lo  = cfg_wr_i && (cfg_addr_i == RA_CNT_LO);
   assign wr_hi  = cfg_wr_i && (cfg_addr_i == RA_CNT_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_cmp_q  <= '0;
         src_msk_q  <= '1;
         tgt_cmp_q  <= '0;
         tgt_msk_q  <= '1;
         sel_code_q <= '0;
         chan_sel_q <= CHS_ALL;
      end else if (cfg_wr_i) begin
         unique case (cfg_addr_i)
            RA_SRC_CMP: src_cmp_q <= cfg_wdata_i[ID_W-1:0];
            RA_SRC_MSK: src_msk_q <= cfg_wdata_i[ID_W-1:0];
            RA_TGT_CMP: tgt_cmp_q <= cfg_wdata_i[ID_W-1:0];
            RA_TGT_MSK: tgt_msk_q <= cfg_wdata_i[ID_W-1:0];
            RA_CTRL: begin
               sel_code_q <= cfg_wdata_i[CODE_W-1:0];
               chan_sel_q <= cfg_wdata_i[CHS_LSB+1:CHS_LSB];
            end
            default: ;
         endcase
      end
   end

   // ---------------- qualification ----------------
   logic src_hit, tgt_hit, chan_pass, code_hit, ev_count;

   idm_id_match #(.ID_W(ID_W)) u_src_match (
      .id_i (ev_src_i),
      .cmp_i(src_cmp_q),
      .msk_i(src_msk_q),
      .hit_o(src_hit)
   );

   idm_id_match #(.ID_W(ID_W)) u_tgt_match (
      .id_i (ev_tgt_i),
      .cmp_i(tgt_cmp_q),
      .msk_i(tgt_msk_q),
      .hit_o(tgt_hit)
   );

   idm_chan_filter #(.CODE_W(CODE_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chan (
      .code_i(sel_code_q),
      .sel_i (chan_sel_q),
      .tag_i (ev_chan_i),
      .pass_o(chan_pass)
   );

   assign code_hit = (ev_code_i == sel_code_q);
   assign ev_count = ev_valid_i && code_hit && src_hit && tgt_hit && chan_pass;

   // ---------------- counter ----------------
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   idm_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (wr_clr),
      .ld_lo_i  (wr_lo),
      .ld_hi_i  (wr_hi),
      .ld_data_i(cfg_wdata_i),
      .inc_i    (ev_count),
      .cnt_o    (cnt),
      .ovf_o    (ovf)
   );

   // ---------------- read mux ----------------
   always_comb begin
      cfg_rdata_o = '0;
      unique case (cfg_raddr_i)
         RA_SRC_CMP: cfg_rdata_o[ID_W-1:0] = src_cmp_q;
         RA_SRC_MSK: cfg_rdata_o[ID_W-1:0] = src_msk_q;
         RA_TGT_CMP: cfg_rdata_o[ID_W-1:0] = tgt_cmp_q;
         RA_TGT_MSK: cfg_rdata_o[ID_W-1:0] = tgt_msk_q;
         RA_CTRL: begin
            cfg_rdata_o[CODE_W-1:0]         = sel_code_q;
            cfg_rdata_o[CHS_LSB+1:CHS_LSB] = chan_sel_q;
         end
         RA_CNT_LO: cfg_rdata_o = cnt[DATA_W-1:0];
         RA_CNT_HI: begin
            cfg_rdata_o[HI_W-1:0]   = cnt[CNT_W-1:DATA_W];
            cfg_rdata_o[DATA_W-1]   = ovf;
         end
         default: cfg_rdata_o = '0;
      endcase
   end

   // R2: a valid event of another code never moves the count
   p_wrong_code_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && !code_hit && !cfg_wr_i) |=> $stable(cnt));
   // R7: reset configuration counts every selected event
   p_open_filters_count_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && code_hit && (&src_msk_q) && (&tgt_msk_q) &&
       chan_sel_q == CHS_ALL && !cfg_wr_i) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: tb/idm_event_counter_bench.sv
module idm_event_counter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [2:0]  cfg_addr_i = '0;
   logic [31:0] cfg_wdata_i = '0;
   logic [2:0]  cfg_raddr_i = '0;
   logic [31:0] cfg_rdata_o;
   logic        ev_valid_i = 1'b0;
   logic [7:0]  ev_code_i = '0;
   logic [10:0] ev_src_i = '0;
   logic [10:0] ev_tgt_i = '0;
   logic [1:0]  ev_chan_i = '0;

   always #10 clk = ~clk;   // 50 MHz

   idm_event_counter u_idm_event_counter (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_raddr_i(cfg_raddr_i), .cfg_rdata_o(cfg_rdata_o),
      .ev_valid_i(ev_valid_i), .ev_code_i(ev_code_i),
      .ev_src_i(ev_src_i), .ev_tgt_i(ev_tgt_i), .ev_chan_i(ev_chan_i)
   );

   int checks = 0;
   int errors = 0;

   // shadow model
   logic [10:0] m_scmp = '0, m_smsk = '1, m_tcmp = '0, m_tmsk = '1;
   logic [7:0]  m_sel = '0;
   logic [1:0]  m_chs = '0;
   logic [47:0] m_cnt = '0;
   logic        m_ovf = 1'b0;

   function automatic logic exp_hit(logic v, logic [7:0] code, logic [10:0] s,
                                    logic [10:0] t, logic [1:0] ch);
      logic ok;
      ok = v && (code == m_sel);
      ok = ok && (((s ^ m_scmp) & ~m_smsk) == 11'd0);     // R3
      ok = ok && (((t ^ m_tcmp) & ~m_tmsk) == 11'd0);     // R4
      if (m_sel >= 8'h47 && m_sel <= 8'h59) begin          // R5 window
         if (m_chs == 2'b10) ok = ok && ch[1];
         else if (m_chs != 2'b00) ok = ok && ch[0];
      end
      return ok;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycle(logic wr, logic [2:0] a, logic [31:0] d,
                        logic v, logic [7:0] code, logic [10:0] s,
                        logic [10:0] t, logic [1:0] ch);
      logic hit;
      @(negedge clk);
      cfg_wr_i = wr; cfg_addr_i = a; cfg_wdata_i = d;
      ev_valid_i = v; ev_code_i = code; ev_src_i = s; ev_tgt_i = t; ev_chan_i = ch;
      hit = exp_hit(v, code, s, t, ch);            // R11: old configuration
      if (wr && a == 3'd7 && d[0]) begin m_cnt = '0; m_ovf = 1'b0; end
      else if (wr && (a == 3'd5 || a == 3'd6)) begin
         if (a == 3'd5) m_cnt[31:0] = d;
         else m_cnt[47:32] = d[15:0];
      end else if (hit) begin
         if (&m_cnt) m_ovf = 1'b1;
         m_cnt = m_cnt + 48'd1;
      end
      if (wr) begin
         case (a)
            3'd0: m_scmp = d[10:0];
            3'd1: m_smsk = d[10:0];
            3'd2: m_tcmp = d[10:0];
            3'd3: m_tmsk = d[10:0];
            3'd4: begin m_sel = d[7:0]; m_chs = d[9:8]; end
            default: ;
         endcase
      end
      @(posedge clk);
      #2;
      cfg_wr_i = 1'b0; ev_valid_i = 1'b0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      cycle(1'b1, a, d, 1'b0, 8'h0, 11'h0, 11'h0, 2'b00);
   endtask

   task automatic ev(logic [7:0] code, logic [10:0] s, logic [10:0] t, logic [1:0] ch);
      cycle(1'b0, 3'd0, 32'h0, 1'b1, code, s, t, ch);
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      cfg_raddr_i = a;
      #1;
      d = cfg_rdata_o;
   endtask

   task automatic check_count(string req);
      logic [31:0] lo, hi;
      rd(3'd5, lo);
      rd(3'd6, hi);
      check(req, {hi[31], hi[15:0], lo}, {m_ovf, m_cnt});
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h1d5a7));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, d); check("R1 src mask", d, 32'h7FF);
      rd(3'd3, d); check("R1 tgt mask", d, 32'h7FF);
      rd(3'd0, d); check("R1 src cmp", d, 0);
      rd(3'd4, d); check("R1 ctrl", d, 0);
      check_count("R1 counter");

      // R7 open filters count all code-0 events; R2 other codes ignored
      for (int i = 0; i < 5; i++) ev(8'h00, 11'($urandom), 11'($urandom), 2'($urandom));
      check_count("R7 open filters");
      for (int i = 0; i < 4; i++) ev(8'h01, 11'($urandom), 11'($urandom), 2'b11);
      check_count("R2 other code ignored");

      // R3 die match: mask cluster bits
      wr(3'd4, 32'h10); wr(3'd0, {21'd0, 6'h2A, 5'd0}); wr(3'd1, 32'h01F);
      ev(8'h10, {6'h2A, 5'b10000}, 11'h0, 2'b00);
      ev(8'h10, {6'h2A, 5'b00011}, 11'h0, 2'b00);
      ev(8'h10, {6'h2B, 5'b00011}, 11'h0, 2'b00);
      check_count("R3 die match");
      // R4 target cluster match independent of die
      wr(3'd1, 32'h7FF); wr(3'd2, 32'h001); wr(3'd3, {21'd0, 6'h3F, 5'd0});
      ev(8'h10, 11'h0, {6'h05, 5'b00001}, 2'b00);
      ev(8'h10, 11'h0, {6'h05, 5'b00000}, 2'b00);
      check_count("R4 target cluster");
      wr(3'd3, 32'h7FF);

      // R5 window edges
      wr(3'd4, {22'd0, 2'b01, 8'h47});
      ev(8'h47, 0, 0, 2'b10); ev(8'h47, 0, 0, 2'b01); ev(8'h47, 0, 0, 2'b11);
      check_count("R5 low edge sel01");
      wr(3'd4, {22'd0, 2'b11, 8'h47});
      ev(8'h47, 0, 0, 2'b10); ev(8'h47, 0, 0, 2'b01);
      check_count("R5 sel11 like sel01");
      wr(3'd4, {22'd0, 2'b10, 8'h59});
      ev(8'h59, 0, 0, 2'b01); ev(8'h59, 0, 0, 2'b10);
      check_count("R5 high edge sel10");
      // R6 just outside window
      wr(3'd4, {22'd0, 2'b10, 8'h5A});
      ev(8'h5A, 0, 0, 2'b01); ev(8'h5A, 0, 0, 2'b00);
      wr(3'd4, {22'd0, 2'b01, 8'h46});
      ev(8'h46, 0, 0, 2'b10);
      check_count("R6 outside window");

      // R11 event in same cycle as config write uses old config
      wr(3'd4, 32'h20);
      cycle(1'b1, 3'd4, 32'h21, 1'b1, 8'h20, 0, 0, 2'b00);
      ev(8'h20, 0, 0, 2'b00);
      check_count("R11 old config");

      // R10 preset and readback
      wr(3'd5, 32'hFFFF_FFFE); wr(3'd6, 32'h0000_FFFF);
      check_count("R10 preset");
      // R8 wrap
      wr(3'd4, 32'h30);
      ev(8'h30, 0, 0, 2'b00); ev(8'h30, 0, 0, 2'b00);
      rd(3'd6, d); check("R8 overflow flag", d, 32'h8000_0000);
      ev(8'h30, 0, 0, 2'b00);
      check_count("R8 sticky after wrap");
      // R10 preset wins over event
      cycle(1'b1, 3'd5, 32'h100, 1'b1, 8'h30, 0, 0, 2'b00);
      check_count("R10 preset priority");
      // R9 clear wins over event
      cycle(1'b1, 3'd7, 32'h1, 1'b1, 8'h30, 0, 0, 2'b00);
      check_count("R9 clear priority");

      // random phases
      for (int p = 0; p < 14; p++) begin
         logic [7:0] codes [6];
         logic [7:0] sel;
         codes = '{8'h47, 8'h59, 8'h50, 8'h46, 8'h5A, 8'h12};
         sel = codes[$urandom % 6];
         wr(3'd4, {22'd0, 2'($urandom), sel});
         wr(3'd0, 32'($urandom)); wr(3'd1, 32'($urandom) | 32'h0F0);
         wr(3'd2, 32'($urandom)); wr(3'd3, 32'($urandom) | 32'h30F);
         for (int i = 0; i < 60; i++) begin
            logic [10:0] s, t;
            s = m_scmp ^ (($urandom % 3 == 0) ? 11'($urandom) : 11'h0);
            t = m_tcmp ^ (($urandom % 3 == 0) ? 11'($urandom) : 11'h0);
            cycle(1'b0, 3'd0, 0, 1'($urandom % 4 != 0),
                  ($urandom % 4 == 0) ? sel + 8'd1 : sel, s, t, 2'($urandom));
         end
         check_count("R2 random R3 R4 R5 R6");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule